// File: doc/BRIEF.md
# Frequent Pattern Word Codec

This block compresses and expands single 32-bit data words by significance. The encoder looks at one word in isolation, finds the cheapest pattern that the word fits, and emits a 3-bit pattern code, a payload that carries only the significant bits, and the payload length in bits. The payload is left-justified in a 32-bit field, so its first significant bit is always bit 31, and every bit below the length is zero.

The decoder takes a pattern code and a payload and rebuilds the original word. It reads only the bits that the code says are significant. A packer that builds variable-length line images can therefore hand the decoder a window that still holds the next code's bits.

The encode and decode paths are independent. Each has a valid/ready handshake on both sides and one register stage between them. Neighbouring words never affect each other.

Top module: `fpc_word_codec`

## Requirements
- R1: An all-zero word encodes as code 3'b000 with length 0 and an all-zero payload.
- R2: A word in the signed range -8..7 that is not zero encodes as code 3'b001 with length 4, and the low nibble is placed in payload[31:28].
- R3: A word in the signed range -128..127 that is not covered by R1 or R2 encodes as code 3'b010 with length 8, and the low byte is placed in payload[31:24].
- R4: A word made of one byte repeated four times that is not covered by R1 to R3 encodes as code 3'b110 with length 8, and that byte is placed in payload[31:24].
- R5: A word in the signed range -32768..32767 that is not covered by R1 to R4 encodes as code 3'b011 with length 16, and the low half-word is placed in payload[31:16].
- R6: A word whose low half-word is zero and that is not covered by R1 to R5 encodes as code 3'b100 with length 16, and the high half-word is placed in payload[31:16].
- R7: A word whose two halves each lie in the signed 16-bit range -128..127, and that is not covered by R1 to R6, encodes as code 3'b101 with length 16. The low byte of the high half goes to payload[31:24] and the low byte of the low half goes to payload[23:16].
- R8: Any other word encodes as code 3'b111 with length 32, and the payload equals the word.
- R9: Encoder payload bits below the first `length` bits (payload[31-length:0]) are always zero.
- R10: The decoder rebuilds the word from the code and payload, and ignores every payload bit beyond the code's length.
- R11: Decoding the encoder's code and payload returns the original word for every input.
- R12: Each path has one register stage. An accepted input appears at the output on the next cycle. The output holds while ready is low, and input ready is low while a held output is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_in_valid | input | 1 | Word offered to encoder |
| enc_in_ready | output | 1 | Encoder can accept |
| enc_in_word | input | 32 | Word to compress |
| enc_out_valid | output | 1 | Code available |
| enc_out_ready | input | 1 | Consumer takes code |
| enc_out_prefix | output | 3 | Pattern code |
| enc_out_payload | output | 32 | Left-justified significant bits |
| enc_out_len | output | 6 | Payload length in bits |
| dec_in_valid | input | 1 | Code offered to decoder |
| dec_in_ready | output | 1 | Decoder can accept |
| dec_in_prefix | input | 3 | Pattern code |
| dec_in_payload | input | 32 | Left-justified payload |
| dec_out_valid | output | 1 | Rebuilt word available |
| dec_out_ready | input | 1 | Consumer takes word |
| dec_out_word | output | 32 | Rebuilt word |

## Verification
Each code is driven with directed words at the edges of its range: the extremes of the signed nibble, byte and half-word ranges and the values just outside them. Repeated bytes that do or do not fall into the signed-byte range show whether a tie goes to the lower code. Half-word cases separate the padded, dual and 16-bit sign-extended classes.

Several thousand pseudo-random words are also run, both raw and shaped to fit each class. For every word, the decoder receives the encoded payload with random noise in the unused tail, so a decoder that reads past the length is caught. A back-pressure episode shows that the output stage holds its value and stalls its input.

// File: rtl/fpwc_pkg.sv
package fpwc_pkg;
   localparam int unsigned FPWC_WORD_W = 32;
   localparam int unsigned FPWC_LEN_W  = $clog2(FPWC_WORD_W) + 1;

   typedef enum logic [2:0] {
      PFX_ZERO = 3'd0,
      PFX_SE4  = 3'd1,
      PFX_SE8  = 3'd2,
      PFX_SE16 = 3'd3,
      PFX_HPAD = 3'd4,
      PFX_DUAL = 3'd5,
      PFX_REPB = 3'd6,
      PFX_RAW  = 3'd7
   } fpwc_pfx_e;

   typedef struct packed {
      fpwc_pfx_e                prefix;
      logic [FPWC_LEN_W-1:0]    len;
      logic [FPWC_WORD_W-1:0]   payload;
   } fpwc_code_t;

   function automatic logic [FPWC_LEN_W-1:0] fpwc_len_of(input fpwc_pfx_e p);
      case (p)
         PFX_ZERO: fpwc_len_of = FPWC_LEN_W'(0);
         PFX_SE4:  fpwc_len_of = FPWC_LEN_W'(4);
         PFX_SE8:  fpwc_len_of = FPWC_LEN_W'(8);
         PFX_REPB: fpwc_len_of = FPWC_LEN_W'(8);
         PFX_SE16: fpwc_len_of = FPWC_LEN_W'(16);
         PFX_HPAD: fpwc_len_of = FPWC_LEN_W'(16);
         PFX_DUAL: fpwc_len_of = FPWC_LEN_W'(16);
         default:  fpwc_len_of = FPWC_LEN_W'(32);
      endcase
   endfunction
endpackage

// File: rtl/fpwc_stage.sv
module fpwc_stage #(
   parameter int unsigned W          = 8,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   if (W < 1) begin : g_bad_w
      $error("fpwc_stage: W must be at least 1");
   end

   if (REGISTERED) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;
      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
         end else if (in_ready) begin
            vld_q <= in_valid;
            if (in_valid) dat_q <= in_data;
         end
      end
   end else begin : g_wire
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
   end
endmodule

// File: rtl/fpwc_classify.sv
module fpwc_classify
   import fpwc_pkg::*;
#(
   parameter int unsigned WORD_W = FPWC_WORD_W
) (
   input  logic [WORD_W-1:0] word,
   output fpwc_code_t        code
);
   if (WORD_W != 32) begin : g_bad_w
      $error("fpwc_classify: only 32-bit words are supported");
   end

   localparam int unsigned HALF_W = WORD_W / 2;

   logic fit_zero, fit_se4, fit_se8, fit_se16, fit_hpad, fit_dual, fit_repb;
   logic hi_fits8, lo_fits8;
   logic [HALF_W-1:0] w_hi, w_lo;

   assign w_hi = word[WORD_W-1:HALF_W];
   assign w_lo = word[HALF_W-1:0];

   // sign-extension test: every bit from k-1 upward equals the top bit
   assign fit_zero = (word == '0);
   assign fit_se4  = (&word[WORD_W-1:3])  | ~(|word[WORD_W-1:3]);
   assign fit_se8  = (&word[WORD_W-1:7])  | ~(|word[WORD_W-1:7]);
   assign fit_se16 = (&word[WORD_W-1:15]) | ~(|word[WORD_W-1:15]);
   assign fit_hpad = (w_lo == '0);
   assign hi_fits8 = (&w_hi[HALF_W-1:7]) | ~(|w_hi[HALF_W-1:7]);
   assign lo_fits8 = (&w_lo[HALF_W-1:7]) | ~(|w_lo[HALF_W-1:7]);
   assign fit_dual = hi_fits8 & lo_fits8;
   assign fit_repb = (word == {4{word[7:0]}});

   fpwc_pfx_e pick;

   // cheapest payload first; equal lengths resolved toward the lower code
   always_comb begin
      if (fit_zero)      pick = PFX_ZERO;
      else if (fit_se4)  pick = PFX_SE4;
      else if (fit_se8)  pick = PFX_SE8;
      else if (fit_repb) pick = PFX_REPB;
      else if (fit_se16) pick = PFX_SE16;
      else if (fit_hpad) pick = PFX_HPAD;
      else if (fit_dual) pick = PFX_DUAL;
      else               pick = PFX_RAW;
   end

   always_comb begin
      code.prefix = pick;
      code.len    = fpwc_len_of(pick);
      case (pick)
         PFX_ZERO: code.payload = '0;
         PFX_SE4:  code.payload = {word[3:0], 28'd0};
         PFX_SE8,
         PFX_REPB: code.payload = {word[7:0], 24'd0};
         PFX_SE16: code.payload = {w_lo, 16'd0};
         PFX_HPAD: code.payload = {w_hi, 16'd0};
         PFX_DUAL: code.payload = {w_hi[7:0], w_lo[7:0], 16'd0};
         default:  code.payload = word;
      endcase
   end
endmodule

// File: rtl/fpwc_expand.sv
module fpwc_expand
   import fpwc_pkg::*;
#(
   parameter int unsigned WORD_W = FPWC_WORD_W
) (
   input  fpwc_pfx_e         prefix,
   input  logic [WORD_W-1:0] payload,
   output logic [WORD_W-1:0] word
);
   if (WORD_W != 32) begin : g_bad_w
      $error("fpwc_expand: only 32-bit words are supported");
   end

   logic [3:0]  nib;
   logic [7:0]  b_a, b_b;
   logic [15:0] half;

   assign nib  = payload[31:28];
   assign b_a  = payload[31:24];
   assign b_b  = payload[23:16];
   assign half = payload[31:16];

   always_comb begin
      case (prefix)
         PFX_ZERO: word = '0;
         PFX_SE4:  word = {{28{nib[3]}}, nib};
         PFX_SE8:  word = {{24{b_a[7]}}, b_a};
         PFX_SE16: word = {{16{half[15]}}, half};
         PFX_HPAD: word = {half, 16'd0};
         PFX_DUAL: word = {{8{b_a[7]}}, b_a, {8{b_b[7]}}, b_b};
         PFX_REPB: word = {4{b_a}};
         default:  word = payload;
      endcase
   end
endmodule

// File: rtl/fpc_word_codec.sv
module fpc_word_codec
   import fpwc_pkg::*;
#(
   parameter int unsigned WORD_W  = FPWC_WORD_W,
   parameter bit          ENC_REG = 1'b1,
   parameter bit          DEC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_in_valid,
   output logic              enc_in_ready,
   input  logic [WORD_W-1:0] enc_in_word,
   output logic              enc_out_valid,
   input  logic              enc_out_ready,
   output logic [2:0]        enc_out_prefix,
   output logic [WORD_W-1:0] enc_out_payload,
   output logic [5:0]        enc_out_len,
   input  logic              dec_in_valid,
   output logic              dec_in_ready,
   input  logic [2:0]        dec_in_prefix,
   input  logic [WORD_W-1:0] dec_in_payload,
   output logic              dec_out_valid,
   input  logic              dec_out_ready,
   output logic [WORD_W-1:0] dec_out_word
);
   localparam int unsigned CODE_W = $bits(fpwc_code_t);

   if (WORD_W != FPWC_WORD_W) begin : g_bad_w
      $error("fpc_word_codec: WORD_W must match the package word width");
   end

   fpwc_code_t code_c, code_q;
   logic [WORD_W-1:0] word_c;

   fpwc_classify #(.WORD_W(WORD_W)) u_classify (
      .word (enc_in_word),
      .code (code_c)
   );

   fpwc_stage #(.W(CODE_W), .REGISTERED(ENC_REG)) u_enc_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (enc_in_valid),
      .in_ready  (enc_in_ready),
      .in_data   (code_c),
      .out_valid (enc_out_valid),
      .out_ready (enc_out_ready),
      .out_data  (code_q)
   );

   assign enc_out_prefix  = code_q.prefix;
   assign enc_out_len     = code_q.len;
   assign enc_out_payload = code_q.payload;

   fpwc_expand #(.WORD_W(WORD_W)) u_expand (
      .prefix  (fpwc_pfx_e'(dec_in_prefix)),
      .payload (dec_in_payload),
      .word    (word_c)
   );

   fpwc_stage #(.W(WORD_W), .REGISTERED(DEC_REG)) u_dec_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dec_in_valid),
      .in_ready  (dec_in_ready),
      .in_data   (word_c),
      .out_valid (dec_out_valid),
      .out_ready (dec_out_ready),
      .out_data  (dec_out_word)
   );
endmodule

// File: rtl/fpwc_checker.sv
module fpwc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        enc_in_valid,
   input logic        enc_in_ready,
   input logic [31:0] enc_in_word,
   input logic        enc_out_valid,
   input logic        enc_out_ready,
   input logic [2:0]  enc_out_prefix,
   input logic [31:0] enc_out_payload,
   input logic [5:0]  enc_out_len,
   input logic        dec_out_valid,
   input logic        dec_out_ready,
   input logic [31:0] dec_out_word
);
   logic [31:0] last_word;
   logic [31:0] tail_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            last_word <= '0;
      else if (enc_in_valid && enc_in_ready) last_word <= enc_in_word;
   end

   assign tail_mask = 32'hFFFF_FFFF >> enc_out_len;

   AST_ENC_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
      enc_in_valid && enc_in_ready |=> enc_out_valid); // R12
   AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_out_payload)
      && $stable(enc_out_prefix) && $stable(enc_out_len)); // R12
   AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_word)); // R12
   AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      enc_in_valid && enc_in_ready && enc_in_word == 32'd0 |=>
      enc_out_prefix == 3'd0 && enc_out_len == 6'd0); // R1
   AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid |-> (enc_out_payload & tail_mask) == 32'd0); // R9
   AST_RAW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      enc_out_valid && enc_out_prefix == 3'd7 |-> enc_out_payload == last_word); // R8
endmodule

bind fpc_word_codec fpwc_checker u_fpwc_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .enc_in_valid    (enc_in_valid),
   .enc_in_ready    (enc_in_ready),
   .enc_in_word     (enc_in_word),
   .enc_out_valid   (enc_out_valid),
   .enc_out_ready   (enc_out_ready),
   .enc_out_prefix  (enc_out_prefix),
   .enc_out_payload (enc_out_payload),
   .enc_out_len     (enc_out_len),
   .dec_out_valid   (dec_out_valid),
   .dec_out_ready   (dec_out_ready),
   .dec_out_word    (dec_out_word)
);

// File: tb/fpc_word_codec_bench.sv
`timescale 1ns/1ps
module fpc_word_codec_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enc_in_valid = 1'b0, enc_out_ready = 1'b1;
   logic [31:0] enc_in_word = '0;
   logic        enc_in_ready, enc_out_valid;
   logic [2:0]  enc_out_prefix;
   logic [31:0] enc_out_payload;
   logic [5:0]  enc_out_len;
   logic        dec_in_valid = 1'b0, dec_out_ready = 1'b1;
   logic [2:0]  dec_in_prefix = '0;
   logic [31:0] dec_in_payload = '0;
   logic        dec_in_ready, dec_out_valid;
   logic [31:0] dec_out_word;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #10 clk = ~clk;

   fpc_word_codec u_fpc_word_codec (.*);

   function automatic logic [31:0] nxt(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   function automatic bit in_rng(input logic [31:0] w, input int lo, input int hi);
      return ($signed(w) >= lo) && ($signed(w) <= hi);
   endfunction

   function automatic bit h8(input logic [15:0] h);
      return ($signed(h) >= -128) && ($signed(h) <= 127);
   endfunction

   task automatic expect_code(input logic [31:0] w, output logic [2:0] p,
                              output int n, output logic [31:0] pl);
      if (w == 0)                           begin p = 0; n = 0;  pl = 0; end
      else if (in_rng(w, -8, 7))            begin p = 1; n = 4;  pl = w << 28; end
      else if (in_rng(w, -128, 127))        begin p = 2; n = 8;  pl = w << 24; end
      else if (w == {4{w[7:0]}})            begin p = 6; n = 8;  pl = w << 24; end
      else if (in_rng(w, -32768, 32767))    begin p = 3; n = 16; pl = w << 16; end
      else if (w[15:0] == 0)                begin p = 4; n = 16; pl = w; end
      else if (h8(w[31:16]) && h8(w[15:0])) begin p = 5; n = 16; pl = {w[23:16], w[7:0], 16'd0}; end
      else                                  begin p = 7; n = 32; pl = w; end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] p);
      case (p)
         3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd6: return "R4";
         3'd3: return "R5"; 3'd4: return "R6"; 3'd5: return "R7"; default: return "R8";
      endcase
   endfunction

   task automatic round_trip(input logic [31:0] w, input logic [31:0] noise);
      logic [2:0] ep; int en; logic [31:0] epl, tail;
      expect_code(w, ep, en, epl);
      @(negedge clk); enc_in_valid = 1'b1; enc_in_word = w;
      @(posedge clk);
      @(negedge clk); enc_in_valid = 1'b0;
      check(enc_out_valid && enc_out_prefix == ep && enc_out_len == 6'(en)
            && enc_out_payload == epl, req_of(ep), "encode",
            {enc_out_prefix, enc_out_len, enc_out_payload}, {ep, 6'(en), epl});
      tail = 32'hFFFF_FFFF >> en;
      check((enc_out_payload & tail) == 0, "R9", "tail", enc_out_payload, epl);
      dec_in_valid = 1'b1; dec_in_prefix = enc_out_prefix;
      dec_in_payload = enc_out_payload | (noise & tail);   // R10 noise past length
      @(posedge clk);
      @(negedge clk); dec_in_valid = 1'b0;
      check(dec_out_valid && dec_out_word == w, "R11", "decode", dec_out_word, w);
   endtask

   initial begin
      #(20.0 * 150000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] wlist [0:27];
      wlist = '{32'h0, 32'h1, 32'h7, 32'hFFFF_FFF8, 32'hFFFF_FFFF, 32'h8,
                32'hFFFF_FFF7, 32'h7F, 32'hFFFF_FF80, 32'h80, 32'h7F7F_7F7F,
                32'h5555_5555, 32'h8080_8080, 32'h7FFF, 32'hFFFF_8000,
                32'h8000, 32'h1234_0000, 32'h8000_0000, 32'h007F_FF80,
                32'hFF80_007F, 32'h0080_0001, 32'h1234_5678, 32'hDEAD_BEEF,
                32'h0001_0000, 32'h0000_FF00, 32'hFFFF_0000, 32'h0012_0034, 32'hA5A5_A5A5};
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!enc_out_valid && !dec_out_valid, "R12", "reset valid", {enc_out_valid, dec_out_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(enc_in_ready && dec_in_ready, "R12", "ready after reset", {enc_in_ready, dec_in_ready}, 2'b11);
      foreach (wlist[i]) round_trip(wlist[i], 32'hFFFF_FFFF);
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r, w;
         lfsr = nxt(lfsr); r = lfsr; lfsr = nxt(lfsr);
         case (i % 8)
            0: w = r;
            1: w = {{28{r[3]}}, r[3:0]};
            2: w = {{24{r[7]}}, r[7:0]};
            3: w = {4{r[7:0]}};
            4: w = {{16{r[15]}}, r[15:0]};
            5: w = {r[31:16], 16'd0};
            6: w = {{8{r[15]}}, r[15:8], {8{r[7]}}, r[7:0]};
            default: w = r ^ lfsr;
         endcase
         round_trip(w, lfsr);
      end
      // R12 back-pressure on encoder output
      @(negedge clk); enc_out_ready = 1'b0; enc_in_valid = 1'b1; enc_in_word = 32'h1234_5678;
      @(posedge clk);
      @(negedge clk); enc_in_word = 32'h0;
      check(enc_out_valid && !enc_in_ready && enc_out_payload == 32'h1234_5678, "R12",
            "stall first", enc_out_payload, 32'h1234_5678);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(enc_out_valid && enc_out_prefix == 3'd7 && enc_out_payload == 32'h1234_5678,
            "R12", "held", enc_out_payload, 32'h1234_5678);
      enc_out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk); enc_in_valid = 1'b0;
      check(enc_out_valid && enc_out_prefix == 3'd0 && enc_out_len == 0, "R12",
            "second after release", enc_out_prefix, 0);
      @(posedge clk);
      @(negedge clk);
      check(!enc_out_valid, "R12", "drained", enc_out_valid, 0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule